// File: doc/BRIEF.md
# Dual-Mode Serial Shift/Counter Port

This block is the serial I/O unit of a small 4-bit controller. A single 4-bit data register works in one of two modes. In shift mode it takes the synchronized serial input into its low end once per instruction cycle. In count mode it counts down once for every high-to-low transition of that same input. An exchange request swaps the register with the accumulator. In the same step it loads the carry flag into a clock-gate latch. That latch decides whether the serial clock output runs.

The controller supplies an instruction-cycle strobe that is one system clock wide, the current enable-register bits, the carry flag and the accumulator value. The block returns the serial data output, the serial clock output, the register contents for the accumulator, and an output-enable for the parallel port. Enable bit 0 selects count mode. Enable bit 2 drives the parallel-port output-enable. Enable bit 3 controls the serial data output. Enable bit 1 is ignored.

Top module: `sio_dual_port`

## Requirements
- R1: While reset is low, and after it is released, the data register reads 0 and the clock-gate latch holds 1. The edge tracker starts in its LOW state, so a low input seen at the first strobe is not counted.
- R2: With enable bit 0 clear, each strobe shifts the register left by one. The LSB takes the serial input as seen through the two-stage synchronizer. Between strobes the register holds its value.
- R3: With enable bit 0 clear, the serial output is the register MSB when enable bit 3 is 1, and it is 0 when enable bit 3 is 0. Shifting goes on in both cases.
- R4: With enable bit 0 set, a strobe whose sample of the synchronized input is 0, where the previous strobe's sample was 1, decrements the register by 1. The count wraps from 0 to 15. Level changes that begin and end between two strobes are not counted.
- R5: With enable bit 0 set, the serial output equals enable bit 3.
- R6: With enable bit 0 clear, the serial clock goes high for exactly the one clock after each strobe edge when the latch is 1. It is 0 at all other times.
- R7: With enable bit 0 set, the serial clock follows the latch level, one clock later.
- R8: An exchange request loads the accumulator value into the register and the carry flag into the latch. It wins over a shift or count on the same edge. The readback port always shows the register contents.
- R9: The parallel-port output-enable equals enable bit 2. Enable bit 1 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock wide |
| si | input | 1 | Serial input (asynchronous) |
| en_bits | input | 4 | Enable-register bits |
| carry_in | input | 1 | Carry flag copied into the clock-gate latch on exchange |
| xchg_req | input | 1 | Exchange request |
| acc_in | input | 4 | Accumulator value to load on exchange |
| so | output | 1 | Serial data output |
| sk | output | 1 | Serial clock output |
| acc_out | output | 4 | Register contents read back to the accumulator |
| lport_oe | output | 1 | Parallel-port output-enable |

## Verification
A wrong register value shows on the readback port in the clock right after the faulty strobe. In shift mode with enable bit 3 set it also reaches the serial output at once. A fault in the edge tracker shows up as a missed or extra decrement at the first strobe that samples the input. A latch fault shows on the serial clock one clock after the next strobe in shift mode, or one clock after the exchange in count mode. The vector walk and the directed cases sample within one clock of each of these points.

// File: rtl/sio_dual_port_pkg.sv
`timescale 1ns/1ps
package sio_dual_port_pkg;
    localparam int DATA_W   = 4;
    localparam int EN_W     = 4;
    localparam int EN_CNT   = 0;
    localparam int EN_NONE  = 1;
    localparam int EN_OE    = 2;
    localparam int EN_SO    = 3;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_COUNT = 2'd2,
        OP_LOAD  = 2'd3
    } reg_op_t;

    typedef enum logic [1:0] {
        SK_IDLE  = 2'd0,
        SK_PULSE = 2'd1,
        SK_LEVEL = 2'd2
    } sk_state_t;
endpackage

// File: rtl/sio_si_tracker.sv
`timescale 1ns/1ps
module sio_si_tracker
    import sio_dual_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic si,
    output logic si_sync,
    output logic fall_evt
);
    logic [SYNC_STAGES-1:0] chain;
    lvl_state_t state_q, state_d;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= si;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign si_sync = chain[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // transitions: sampled only at the strobe
    always_comb begin
        state_d = state_q;
        if (cyc_stb) begin
            unique case (state_q)
                LVL_LOW:  if (si_sync)  state_d = LVL_HIGH;
                LVL_HIGH: if (!si_sync) state_d = LVL_LOW;
                default:  state_d = LVL_LOW;
            endcase
        end
    end

    // outputs
    always_comb begin
        fall_evt = 1'b0;
        unique case (state_q)
            LVL_HIGH: fall_evt = cyc_stb && !si_sync;
            LVL_LOW:  fall_evt = 1'b0;
            default:  fall_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_data_reg.sv
`timescale 1ns/1ps
module sio_data_reg
    import sio_dual_port_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_op_t      op,
    input  logic [W-1:0] load_val,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    logic [W-1:0] d;

    always_comb begin
        d = q;
        unique case (op)
            OP_HOLD:  d = q;
            OP_SHIFT: d = {q[W-2:0], ser_in};
            OP_COUNT: d = q - ONE;
            OP_LOAD:  d = load_val;
            default:  d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sio_sk_gen.sv
`timescale 1ns/1ps
module sio_sk_gen
    import sio_dual_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_mode,
    input  logic cyc_stb,
    input  logic load_latch,
    input  logic latch_val,
    output logic sk
);
    logic      gate_q;
    sk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)          gate_q <= 1'b1;
        else if (load_latch) gate_q <= latch_val;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SK_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = SK_IDLE;
        if (cnt_mode) state_d = gate_q ? SK_LEVEL : SK_IDLE;
        else          state_d = (cyc_stb && gate_q) ? SK_PULSE : SK_IDLE;
    end

    // outputs
    always_comb begin
        sk = 1'b0;
        unique case (state_q)
            SK_IDLE:  sk = 1'b0;
            SK_PULSE: sk = 1'b1;
            SK_LEVEL: sk = 1'b1;
            default:  sk = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_dual_port.sv
`timescale 1ns/1ps
module sio_dual_port
    import sio_dual_port_pkg::*;
#(
    parameter int W           = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_stb,
    input  logic         si,
    input  logic [3:0]   en_bits,
    input  logic         carry_in,
    input  logic         xchg_req,
    input  logic [W-1:0] acc_in,
    output logic         so,
    output logic         sk,
    output logic [W-1:0] acc_out,
    output logic         lport_oe
);
    logic    si_sync, fall_evt, cnt_mode, so_en;
    logic    unused_en1;
    reg_op_t op;
    logic [W-1:0] q;

    assign cnt_mode   = en_bits[EN_CNT];
    assign so_en      = en_bits[EN_SO];
    assign unused_en1 = en_bits[EN_NONE];

    sio_si_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_trk (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .si(si),
        .si_sync(si_sync), .fall_evt(fall_evt)
    );

    always_comb begin
        op = OP_HOLD;
        if (xchg_req)               op = OP_LOAD;
        else if (cyc_stb && !cnt_mode) op = OP_SHIFT;
        else if (cnt_mode && fall_evt) op = OP_COUNT;
    end

    sio_data_reg #(.W(W)) u_reg (
        .clk(clk), .rst_n(rst_n), .op(op), .load_val(acc_in),
        .ser_in(si_sync), .q(q)
    );

    sio_sk_gen u_sk (
        .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .cyc_stb(cyc_stb),
        .load_latch(xchg_req), .latch_val(carry_in), .sk(sk)
    );

    always_comb begin
        if (cnt_mode) so = so_en;
        else          so = so_en & q[W-1];
    end

    assign acc_out  = q;
    assign lport_oe = en_bits[EN_OE];
endmodule

// File: rtl/sio_dual_port_chk.sv
`timescale 1ns/1ps
module sio_dual_port_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_stb,
    input logic [3:0]   en_bits,
    input logic         xchg_req,
    input logic [W-1:0] acc_in,
    input logic         so,
    input logic         sk,
    input logic [W-1:0] acc_out,
    input logic         lport_oe
);
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !xchg_req && !en_bits[0]) |=> (acc_out[W-1:1] == $past(acc_out[W-2:0]))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !xchg_req) |=> $stable(acc_out)); // R2
    AST_SO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bits[0] && !en_bits[3]) |-> !so); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && en_bits[0] && !xchg_req) |=>
        (acc_out == $past(acc_out) || acc_out == $past(acc_out) - 1'b1)); // R4
    AST_CNT_SO: assert property (@(posedge clk) disable iff (!rst_n)
        en_bits[0] |-> (so == en_bits[3])); // R5
    AST_SK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !en_bits[0]) |=> !sk); // R6
    AST_XCHG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_req |=> (acc_out == $past(acc_in))); // R8
    AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        lport_oe == en_bits[2]); // R9
endmodule

bind sio_dual_port sio_dual_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .en_bits(en_bits),
    .xchg_req(xchg_req), .acc_in(acc_in), .so(so), .sk(sk),
    .acc_out(acc_out), .lport_oe(lport_oe)
);

// File: tb/sio_dual_port_bench.sv
`timescale 1ns/1ps
module sio_dual_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       si = 1'b0;
    logic [3:0] en_bits = 4'b0000;
    logic       carry_in = 1'b0;
    logic       xchg_req = 1'b0;
    logic [3:0] acc_in = 4'b0000;
    logic       so, sk, lport_oe;
    logic [3:0] acc_out;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sio_dual_port u_sio_dual_port (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .si(si),
        .en_bits(en_bits), .carry_in(carry_in), .xchg_req(xchg_req),
        .acc_in(acc_in), .so(so), .sk(sk), .acc_out(acc_out),
        .lport_oe(lport_oe)
    );

    // {en[4], si, xchg, acc[4], carry, exp_reg[4], so, sk_at, sk_late, oe}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R6
        {4'b1000, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R3
        {4'b1000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0101, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
        {4'b1100, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b1011, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 R9
        {4'b1100, 1'b0, 1'b1, 4'b0110, 1'b0, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b1}, // R8
        {4'b1000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 latch 0
        {4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1100, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 R5
        {4'b1001, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1100, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R5
        {4'b1001, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b1100, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 rise
        {4'b1001, 1'b0, 1'b1, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 R7
        {4'b1001, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0}, // R7
        {4'b0011, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 wrap R9
        {4'b0010, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1110, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 R9
        {4'b1010, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b1101, 1'b1, 1'b1, 1'b0, 1'b0}  // R2 R3
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one instruction: set inputs, let sync settle, strobe, sample
    task automatic instr(input logic [3:0] en, input logic s, input logic x,
                         input logic [3:0] a, input logic c,
                         output logic so_s, output logic sk_at, output logic sk_late);
        @(negedge clk);
        en_bits = en; si = s;
        repeat (2) @(negedge clk);
        cyc_stb = 1'b1; xchg_req = x; acc_in = a; carry_in = c;
        @(negedge clk);
        cyc_stb = 1'b0; xchg_req = 1'b0;
        so_s = so; sk_at = sk;
        @(negedge clk);
        sk_late = sk;
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic so_s, sk_at, sk_late;
        repeat (3) @(negedge clk);
        chk("R1 reset reg", acc_out, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset reg", acc_out, 4'h0);
        chk("R3 reset so", {3'b0, so}, 4'h0);
        chk("R6 sk idle", {3'b0, sk}, 4'h0);
        chk("R9 reset oe", {3'b0, lport_oe}, 4'h0);

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            instr(v[18:15], v[14], v[13], v[12:9], v[8], so_s, sk_at, sk_late);
            chk("R2/R4/R8 reg", acc_out, v[7:4]);
            chk("R3/R5 so", {3'b0, so_s}, {3'b0, v[3]});
            chk("R6/R7 sk at strobe", {3'b0, sk_at}, {3'b0, v[2]});
            chk("R6/R7 sk after", {3'b0, sk_late}, {3'b0, v[1]});
            chk("R9 oe", {3'b0, lport_oe}, {3'b0, v[0]});
        end

        // R4: a low pulse that lies between strobes is not counted
        instr(4'b0001, 1'b1, 1'b0, 4'h0, 1'b0, so_s, sk_at, sk_late);
        chk("R4 no edge", acc_out, 4'hD);
        @(negedge clk); si = 1'b0;
        repeat (2) @(negedge clk); si = 1'b1;
        instr(4'b0001, 1'b1, 1'b0, 4'h0, 1'b0, so_s, sk_at, sk_late);
        chk("R4 short pulse ignored", acc_out, 4'hD);
        instr(4'b0001, 1'b0, 1'b0, 4'h0, 1'b0, so_s, sk_at, sk_late);
        chk("R4 sampled fall counted", acc_out, 4'hC);

        // R1: reset mid-run in count mode
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid reset reg", acc_out, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 latch set -> R7 sk level", {3'b0, sk}, 4'h1);
        instr(4'b0001, 1'b0, 1'b0, 4'h0, 1'b0, so_s, sk_at, sk_late);
        chk("R1 tracker starts low", acc_out, 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule